// File: doc/BRIEF.md
# Rectangular Masked Byte-Region Mover

This block copies a rectangle of bytes from one place in memory to another. Software-side logic supplies a source byte address, a destination byte address, a stride for each side (the byte distance from one row's start to the next), a row width in bytes, a row count and a copy mode. The engine then walks the rectangle row by row. It fetches the source through word-wide reads and writes the destination with word-wide writes that carry one strobe per byte lane.

Either origin may sit on any byte boundary. Source bytes are shifted into destination lanes through a two-word window. Each source word a row touches is therefore read exactly once, and each destination word the row touches is written at most once. The destination is never read. Transparent copies work by dropping byte strobes according to the source byte value. When a destination word is left with no strobe, its write is skipped altogether. The block is meant for sprite and glyph blits, mask stamping, and rectangular moves where the source and destination regions do not overlap.

Top module: `rect_mover`

## Requirements
- R1: With mode 0 or mode 3, after `done` every byte `dst + r*dstStride + j` holds the former value of `src + r*srcStride + j` (0 <= r < rows, 0 <= j < width), and no other memory byte changes.
- R2: With mode 1, only destination bytes whose source byte is non-zero are written. Bytes under a zero source byte keep their old value.
- R3: With mode 2, only destination bytes whose source byte is zero are written. Every other destination byte keeps its old value.
- R4: Every read targets a word that overlaps the source span of some row of the current move, so destination-only words are never read.
- R5: A row whose source starts at lane s issues exactly floor((s + width - 1)/4) + 1 reads, and each source word of the row is read once.
- R6: Every request is a whole 32-bit word at a word-aligned byte address with little-endian lanes: byte address 4a+l sits in lane l, on data bits [8l+7:8l], with strobe bit l.
- R7: A destination word is written if, and only if, at least one of its bytes is selected by the mode. A write is never issued with all strobes clear.
- R8: A start with width 0 or row count 0 raises `done` in the cycle after start, leaves `busy` low, and issues no request.
- R9: After an accepted start of a non-empty move, `busy` is high from the next cycle until the move ends. `done` is a one-cycle pulse during which `busy` is low.
- R10: A request held while `memReqReady` is low keeps its address and direction unchanged. Only one read is outstanding, and the engine waits for its response before issuing the next request.
- R11: During and after reset, `busy`, `done` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (sampled while idle) |
| modeIn | input | 2 | 0/3 plain, 1 non-zero only, 2 zero only |
| srcAddr | input | ADDR_W | Source origin byte address |
| dstAddr | input | ADDR_W | Destination origin byte address |
| srcStride | input | ADDR_W | Source row-to-row byte distance |
| dstStride | input | ADDR_W | Destination row-to-row byte distance |
| widthIn | input | LEN_W | Bytes per row |
| rowsIn | input | LEN_W | Number of rows |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle end-of-move pulse |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | ADDR_W | Word-aligned byte address |
| memReqWdata | output | DATA_W | Write data |
| memReqBe | output | DATA_W/8 | Per-lane write strobes |
| memRspValid | input | 1 | Read data valid (in order) |
| memRspData | input | DATA_W | Read data |

## Verification
The bench builds the block with ADDR_W = 10, LEN_W = 6 and DATA_W = 32, against a 1 KiB byte-array memory model. With these values, every lane pairing of source and destination, rows shorter than one word, rows spanning several words and strides that are not multiples of four all fit in a small region. The narrow address also allows an exact full-memory comparison after every move. Some moves throttle `memReqReady`, to exercise request holding. One move draws from an all-zero area in non-zero mode, which forces every write of that move to be dropped.

// File: rtl/rect_mover_pkg.sv
package rect_mover_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'd0,
    MODE_SOLID  = 2'd1,
    MODE_HOLES  = 2'd2,
    MODE_PLAIN3 = 2'd3
  } moveMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // empty the realignment window
    logic push;      // shift one element into the window
    logic pushZero;  // element is virtual: push zeros instead of read data
    logic firstWord; // current destination word is the first of the row
    logic lastWord;  // current destination word is the last of the row
  } dpCtl_t;

endpackage

// File: rtl/rect_mover_ctrl.sv
module rect_mover_ctrl
  import rect_mover_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [1:0]                 modeIn,
  input  logic [ADDR_W-1:0]          srcAddr,
  input  logic [ADDR_W-1:0]          dstAddr,
  input  logic [ADDR_W-1:0]          srcStride,
  input  logic [ADDR_W-1:0]          dstStride,
  input  logic [LEN_W-1:0]           widthIn,
  input  logic [LEN_W-1:0]           rowsIn,
  output logic                       busy,
  output logic                       done,
  output logic                       memReqValid,
  input  logic                       memReqReady,
  output logic                       memReqWrite,
  output logic [ADDR_W-1:0]          memReqAddr,
  input  logic                       memRspValid,
  input  logic                       anyByte,
  output dpCtl_t                     dpCtl,
  output logic [$clog2(DATA_W/8)-1:0] shiftAmt,
  output logic [$clog2(DATA_W/8)-1:0] dstLane,
  output logic [$clog2(DATA_W/8)-1:0] endLane,
  output moveMode_e                  modeOut
);

  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);
  localparam int CNT_W  = LEN_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_FETCH, ST_RWAIT, ST_WRITE, ST_DONE
  } state_e;

  state_e              state;
  moveMode_e           modeR;
  logic [ADDR_W-1:0]   rowSrc, rowDst, srcStrideR, dstStrideR;
  logic [ADDR_W-1:0]   srcRdAddr, dstWrAddr;
  logic [LEN_W-1:0]    widthR, rowsR, rowCnt;
  logic [CNT_W-1:0]    nSrcR, nDstR, tCnt, kCnt;
  logic                skipR;
  logic [LANE_W-1:0]   shiftR, dstLaneR, endLaneR;

  // per-row geometry, taken from the current row origins
  logic [LANE_W-1:0]   srcLaneC, dstLaneC;
  logic [CNT_W-1:0]    spanSrc, spanDst, nSrcC, nDstC;

  always_comb begin
    srcLaneC = rowSrc[LANE_W-1:0];
    dstLaneC = rowDst[LANE_W-1:0];
    spanSrc  = CNT_W'(srcLaneC) + CNT_W'(widthR) - CNT_W'(1);
    spanDst  = CNT_W'(dstLaneC) + CNT_W'(widthR) - CNT_W'(1);
    nSrcC    = (spanSrc >> LANE_W) + CNT_W'(1);
    nDstC    = (spanDst >> LANE_W) + CNT_W'(1);
  end

  // stream element tCnt maps to source word (tCnt - skip); real when in range
  logic elemReal, goWrite, lastDst, lastRow;
  always_comb begin
    elemReal = (tCnt >= CNT_W'(skipR)) && (tCnt < CNT_W'(skipR) + nSrcR);
    goWrite  = (tCnt + CNT_W'(1)) == (kCnt + CNT_W'(2));
    lastDst  = kCnt == (nDstR - CNT_W'(1));
    lastRow  = rowCnt == (rowsR - LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      modeR      <= MODE_PLAIN;
      rowSrc     <= '0;
      rowDst     <= '0;
      srcStrideR <= '0;
      dstStrideR <= '0;
      srcRdAddr  <= '0;
      dstWrAddr  <= '0;
      widthR     <= '0;
      rowsR      <= '0;
      rowCnt     <= '0;
      nSrcR      <= '0;
      nDstR      <= '0;
      tCnt       <= '0;
      kCnt       <= '0;
      skipR      <= 1'b0;
      shiftR     <= '0;
      dstLaneR   <= '0;
      endLaneR   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          modeR      <= moveMode_e'(modeIn);
          rowSrc     <= srcAddr;
          rowDst     <= dstAddr;
          srcStrideR <= srcStride;
          dstStrideR <= dstStride;
          widthR     <= widthIn;
          rowsR      <= rowsIn;
          rowCnt     <= '0;
          state      <= (widthIn == '0 || rowsIn == '0) ? ST_DONE : ST_SETUP;
        end
        ST_SETUP: begin
          nSrcR     <= nSrcC;
          nDstR     <= nDstC;
          skipR     <= srcLaneC < dstLaneC;
          shiftR    <= srcLaneC - dstLaneC;
          dstLaneR  <= dstLaneC;
          endLaneR  <= spanDst[LANE_W-1:0];
          srcRdAddr <= {rowSrc[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
          dstWrAddr <= {rowDst[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
          tCnt      <= '0;
          kCnt      <= '0;
          state     <= ST_FETCH;
        end
        ST_FETCH: begin
          if (elemReal) begin
            if (memReqReady) state <= ST_RWAIT;
          end else begin
            tCnt  <= tCnt + CNT_W'(1);
            state <= goWrite ? ST_WRITE : ST_FETCH;
          end
        end
        ST_RWAIT: if (memRspValid) begin
          tCnt      <= tCnt + CNT_W'(1);
          srcRdAddr <= srcRdAddr + ADDR_W'(BYTES);
          state     <= goWrite ? ST_WRITE : ST_FETCH;
        end
        ST_WRITE: if (!anyByte || memReqReady) begin
          dstWrAddr <= dstWrAddr + ADDR_W'(BYTES);
          if (!lastDst) begin
            kCnt  <= kCnt + CNT_W'(1);
            state <= ST_FETCH;
          end else if (lastRow) begin
            state <= ST_DONE;
          end else begin
            rowSrc <= rowSrc + srcStrideR;
            rowDst <= rowDst + dstStrideR;
            rowCnt <= rowCnt + LEN_W'(1);
            state  <= ST_SETUP;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memReqValid     = (state == ST_FETCH && elemReal) || (state == ST_WRITE && anyByte);
    memReqWrite     = state == ST_WRITE;
    memReqAddr      = (state == ST_WRITE) ? dstWrAddr : srcRdAddr;
    dpCtl.clear     = state == ST_SETUP;
    dpCtl.pushZero  = state == ST_FETCH && !elemReal;
    dpCtl.push      = dpCtl.pushZero || (state == ST_RWAIT && memRspValid);
    dpCtl.firstWord = kCnt == '0;
    dpCtl.lastWord  = lastDst;
    busy            = state != ST_IDLE && state != ST_DONE;
    done            = state == ST_DONE;
    shiftAmt        = shiftR;
    dstLane         = dstLaneR;
    endLane         = endLaneR;
    modeOut         = modeR;
  end

  // R10
  reqHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  // R10
  oneReadOutstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && !memReqWrite) |=> !memReqValid);

  // R9
  donePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  doneNotBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  startReact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> (busy || done));

endmodule

// File: rtl/rect_mover_dp.sv
module rect_mover_dp
  import rect_mover_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtl_t                      ctl,
  input  logic [DATA_W-1:0]           rspData,
  input  logic [$clog2(DATA_W/8)-1:0] shiftAmt,
  input  logic [$clog2(DATA_W/8)-1:0] dstLane,
  input  logic [$clog2(DATA_W/8)-1:0] endLane,
  input  moveMode_e                   mode,
  output logic [DATA_W-1:0]           wdata,
  output logic [DATA_W/8-1:0]         be,
  output logic                        anyByte
);

  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);

  // two-word realignment window: hiQ is the newest element
  logic [DATA_W-1:0]   loQ, hiQ;
  logic [2*DATA_W-1:0] window;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      loQ <= '0;
      hiQ <= '0;
    end else if (ctl.push) begin
      loQ <= hiQ;
      hiQ <= ctl.pushZero ? '0 : rspData;
    end
  end

  always_comb begin
    window = {hiQ, loQ} >> {shiftAmt, 3'b000};
    wdata  = window[DATA_W-1:0];
  end

  logic [BYTES-1:0] laneIn, laneKeep;

  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    logic [7:0] byteV;
    assign byteV       = wdata[8*l +: 8];
    assign laneIn[l]   = (!ctl.firstWord || (LANE_W'(l) >= dstLane)) &&
                         (!ctl.lastWord  || (LANE_W'(l) <= endLane));
    assign laneKeep[l] = (mode == MODE_SOLID) ? (byteV != 8'h00) :
                         (mode == MODE_HOLES) ? (byteV == 8'h00) : 1'b1;
  end

  assign be      = laneIn & laneKeep;
  assign anyByte = |be;

endmodule

// File: rtl/rect_mover.sv
module rect_mover
  import rect_mover_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          modeIn,
  input  logic [ADDR_W-1:0]   srcAddr,
  input  logic [ADDR_W-1:0]   dstAddr,
  input  logic [ADDR_W-1:0]   srcStride,
  input  logic [ADDR_W-1:0]   dstStride,
  input  logic [LEN_W-1:0]    widthIn,
  input  logic [LEN_W-1:0]    rowsIn,
  output logic                busy,
  output logic                done,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic                memReqWrite,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [DATA_W-1:0]   memReqWdata,
  output logic [DATA_W/8-1:0] memReqBe,
  input  logic                memRspValid,
  input  logic [DATA_W-1:0]   memRspData
);

  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);

  dpCtl_t            dpCtl;
  logic [LANE_W-1:0] shiftAmt, dstLane, endLane;
  moveMode_e         modeCur;
  logic              anyByte;

  rect_mover_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .srcStride(srcStride), .dstStride(dstStride),
    .widthIn(widthIn), .rowsIn(rowsIn), .busy(busy), .done(done),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .anyByte(anyByte),
    .dpCtl(dpCtl), .shiftAmt(shiftAmt), .dstLane(dstLane), .endLane(endLane),
    .modeOut(modeCur)
  );

  rect_mover_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .rspData(memRspData),
    .shiftAmt(shiftAmt), .dstLane(dstLane), .endLane(endLane), .mode(modeCur),
    .wdata(memReqWdata), .be(memReqBe), .anyByte(anyByte)
  );

  logic [BYTES-1:0] zeroLane;
  for (genvar l = 0; l < BYTES; l++) begin : g_zero
    assign zeroLane[l] = memReqWdata[8*l +: 8] == 8'h00;
  end

  // R7
  noEmptyWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (memReqBe != '0));

  // R2
  solidLanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && modeCur == MODE_SOLID) |-> ((memReqBe & zeroLane) == '0));

  // R3
  holeLanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && modeCur == MODE_HOLES) |-> ((memReqBe & ~zeroLane) == '0));

endmodule

// File: tb/rect_mover_tb.sv
module rect_mover_tb;

  localparam int ADDR_W    = 10;
  localparam int LEN_W     = 6;
  localparam int DATA_W    = 32;
  localparam int BYTES     = DATA_W / 8;
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int NV        = 7;

  typedef struct packed {
    logic [1:0]        mode;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] ss;
    logic [ADDR_W-1:0] ds;
    logic [LEN_W-1:0]  w;
    logic [LEN_W-1:0]  rows;
  } vec_t;

  // mode, src, dst, srcStride, dstStride, width, rows
  localparam vec_t VECS [NV] = '{
    '{2'd0, 10'd0,   10'd512, 10'd16, 10'd16, 6'd8,  6'd3},
    '{2'd0, 10'd5,   10'd530, 10'd20, 10'd24, 6'd13, 6'd4},
    '{2'd0, 10'd67,  10'd600, 10'd12, 10'd9,  6'd1,  6'd5},
    '{2'd1, 10'd130, 10'd700, 10'd32, 10'd40, 6'd21, 6'd3},
    '{2'd2, 10'd201, 10'd803, 10'd17, 10'd30, 6'd10, 6'd4},
    '{2'd3, 10'd300, 10'd900, 10'd8,  10'd8,  6'd3,  6'd2},
    '{2'd1, 10'd400, 10'd950, 10'd8,  10'd12, 6'd6,  6'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic              start = 1'b0;
  logic [1:0]        modeIn = '0;
  logic [ADDR_W-1:0] srcAddr = '0, dstAddr = '0, srcStride = '0, dstStride = '0;
  logic [LEN_W-1:0]  widthIn = '0, rowsIn = '0;
  logic              busy, done, memReqValid, memReqReady, memReqWrite;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DATA_W-1:0] memReqWdata, memRspData;
  logic [BYTES-1:0]  memReqBe;
  logic              memRspValid;

  rect_mover #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .srcStride(srcStride), .dstStride(dstStride),
    .widthIn(widthIn), .rowsIn(rowsIn), .busy(busy), .done(done),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .memReqBe(memReqBe),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // memory model and traffic monitor
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] expMem [MEM_BYTES];
  int   readCnt, writeCnt, badRead, badAlign, emptyWrite, stallCnt;
  logic stallOn = 1'b0;
  logic clrStats = 1'b0;
  vec_t curV;

  function automatic logic [7:0] initByte(int i);
    if (i >= 400 && i < 432) return 8'h00;
    if (i % 5 == 0) return 8'h00;
    return 8'((i * 7 + 3) % 256);
  endfunction

  function automatic bit readOk(int a);
    for (int r = 0; r < int'(curV.rows); r++) begin
      int srow = int'(curV.src) + r * int'(curV.ss);
      if (a >= (srow / 4) * 4 && a <= ((srow + int'(curV.w) - 1) / 4) * 4) return 1'b1;
    end
    return 1'b0;
  endfunction

  assign memReqReady = stallOn ? (stallCnt % 3 != 0) : 1'b1;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= initByte(i);
      memRspValid <= 1'b0;
      memRspData  <= '0;
      readCnt <= 0; writeCnt <= 0; badRead <= 0; badAlign <= 0; emptyWrite <= 0;
      stallCnt <= 0;
    end else begin
      stallCnt    <= stallCnt + 1;
      memRspValid <= 1'b0;
      if (clrStats) begin
        readCnt <= 0; writeCnt <= 0; badRead <= 0; badAlign <= 0; emptyWrite <= 0;
      end else if (memReqValid && memReqReady) begin
        if (memReqAddr[1:0] != 2'b00) badAlign <= badAlign + 1;
        if (memReqWrite) begin
          writeCnt <= writeCnt + 1;
          if (memReqBe == '0) emptyWrite <= emptyWrite + 1;
          for (int l = 0; l < BYTES; l++)
            if (memReqBe[l]) mem[int'({memReqAddr[ADDR_W-1:2], 2'b00}) + l] <= memReqWdata[8*l +: 8];
        end else begin
          readCnt <= readCnt + 1;
          if (!readOk(int'(memReqAddr))) badRead <= badRead + 1;
          memRspValid <= 1'b1;
          for (int l = 0; l < BYTES; l++)
            memRspData[8*l +: 8] <= mem[int'({memReqAddr[ADDR_W-1:2], 2'b00}) + l];
        end
      end
    end
  end

  int checkCnt = 0, failCnt = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit incl(logic [1:0] m, logic [7:0] b);
    if (m == 2'd1) return b != 8'h00;
    if (m == 2'd2) return b == 8'h00;
    return 1'b1;
  endfunction

  task automatic buildModel(input vec_t v, output int expR, output int expW);
    expR = 0;
    expW = 0;
    for (int i = 0; i < MEM_BYTES; i++) expMem[i] = mem[i];
    for (int r = 0; r < int'(v.rows); r++) begin
      int srow = int'(v.src) + r * int'(v.ss);
      int drow = int'(v.dst) + r * int'(v.ds);
      for (int j = 0; j < int'(v.w); j++)
        if (incl(v.mode, mem[srow + j])) expMem[drow + j] = mem[srow + j];
      expR += ((srow % 4) + int'(v.w) - 1) / 4 + 1;
      for (int wa = drow / 4; wa <= (drow + int'(v.w) - 1) / 4; wa++) begin
        bit any = 1'b0;
        for (int l = 0; l < 4; l++) begin
          int a = wa * 4 + l;
          if (a >= drow && a < drow + int'(v.w) && incl(v.mode, mem[srow + a - drow])) any = 1'b1;
        end
        if (any) expW++;
      end
    end
  endtask

  task automatic pulseStart(input vec_t v);
    @(negedge clk);
    clrStats = 1'b1;
    @(negedge clk);
    clrStats  = 1'b0;
    curV      = v;
    modeIn    = v.mode;
    srcAddr   = v.src;
    dstAddr   = v.dst;
    srcStride = v.ss;
    dstStride = v.ds;
    widthIn   = v.w;
    rowsIn    = v.rows;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = done;
    for (int c = 0; c < 5000 && !seen; c++) begin
      @(negedge clk);
      seen = done;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    int expR, expW, mism;
    bit seen;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R11 done in reset", int'(done), 0);
    chk(memReqValid == 1'b0, "R11 memReqValid in reset", int'(memReqValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && memReqValid == 1'b0, "R11 idle after reset", int'(busy), 0);

    for (int n = 0; n < NV; n++) begin
      stallOn = n[0];
      buildModel(VECS[n], expR, expW);
      pulseStart(VECS[n]);
      // R9 busy in the cycle after start
      chk(busy == 1'b1 && done == 1'b0, "R9 busy after start", int'(busy), 1);
      waitDone(seen);
      chk(seen && !busy, "R9 done pulse with busy low", int'(seen), 1);
      @(negedge clk);
      chk(done == 1'b0, "R9 done lasts one cycle", int'(done), 0);
      mism = 0;
      for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== expMem[i]) mism++;
      if (VECS[n].mode == 2'd1)      chk(mism == 0, "R2 memory image", mism, 0);
      else if (VECS[n].mode == 2'd2) chk(mism == 0, "R3 memory image", mism, 0);
      else                           chk(mism == 0, "R1 memory image", mism, 0);
      chk(readCnt == expR, "R5 read count", readCnt, expR);
      chk(badRead == 0, "R4 reads outside source rows", badRead, 0);
      chk(writeCnt == expW, "R7 write count", writeCnt, expW);
      chk(badAlign == 0 && emptyWrite == 0, "R6 aligned accesses, R7 no empty strobe", badAlign + emptyWrite, 0);
    end

    // R8 width zero
    stallOn = 1'b0;
    pulseStart('{2'd0, 10'd0, 10'd512, 10'd4, 10'd4, 6'd0, 6'd3});
    chk(done == 1'b1 && busy == 1'b0, "R8 width zero done at once", int'(done), 1);
    repeat (3) @(negedge clk);
    chk(readCnt + writeCnt == 0, "R8 width zero no traffic", readCnt + writeCnt, 0);

    // R8 rows zero
    pulseStart('{2'd0, 10'd0, 10'd512, 10'd4, 10'd4, 6'd5, 6'd0});
    chk(done == 1'b1 && busy == 1'b0, "R8 rows zero done at once", int'(done), 1);
    repeat (3) @(negedge clk);
    chk(readCnt + writeCnt == 0, "R8 rows zero no traffic", readCnt + writeCnt, 0);
    chk(memReqValid == 1'b0 && busy == 1'b0, "R10 idle after moves", int'(memReqValid), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule